// File: doc/BRIEF.md
# GPIO Port with Polarity and Change Interrupt

This block is the register bank behind a bidirectional general-purpose port of parameterisable width (eight bits by default). A bus front end decodes transactions into a two-bit register select, a write strobe and a read strobe. The pin levels arrive already synchronised. Each bit has a direction setting, an output value and an input inversion flag. The bank drives the pad output values and output enables. It returns read data for the selected register.

The block has a change detector. It keeps a reference copy of the input pins. It pulls an active-low interrupt line whenever a pin that is set as an input differs from that reference. Reading the input register loads the present pins into the reference, and this releases the line. The line is also released when the pins return to the reference value. The interrupt is registered, so it never glitches. Released means the output is high; an open-drain pad would then float.

Register selects, which software decodes: 0 = input (read only), 1 = output, 2 = inversion, 3 = direction.

Top module: `gpio_port_bank`

## Requirements
- R1: Reset sets the following values. Output register all ones, inversion register all zeros, direction register all ones (every pin an input), `oe_o` all zeros, `out_o` all zeros and `irq_no` high.
- R2: With select 0, `rdata_o` equals `pin_i` XOR the inversion register. This holds for every bit, whatever its direction.
- R3: A set inversion bit inverts that bit of the select-0 read data. A clear inversion bit leaves it as is. The inversion register reads back at select 2.
- R4: Select 1 reads the stored output register, not the pin level.
- R5: A direction bit of 0 makes the pin an output: `oe_o` is 1 and `out_o` carries the output register bit. A direction bit of 1 gives `oe_o` = 0 and `out_o` = 0. Direction reads back at select 3.
- R6: A write with select 0 changes no register, no port output and no interrupt state.
- R7: If an input-configured pin differs from the reference, `irq_no` goes low after the next clock edge.
- R8: A read strobe with select 0 loads the pins into the reference. `irq_no` is high after that edge.
- R9: If the pins return to the reference value with no read, `irq_no` goes high again after the next edge.
- R10: Pins configured as outputs (direction bit 0) never cause the interrupt.
- R11: The change comparison uses raw pin levels. Writing the inversion register alone does not raise the interrupt.
- R12: Reset clears the reference to all zeros. A high input pin after reset raises the interrupt until the first input read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data for the selected register |
| pin_i | input | WIDTH | Synchronised pin levels |
| out_o | output | WIDTH | Pad output values |
| oe_o | output | WIDTH | Pad output enables, active high |
| irq_no | output | 1 | Change interrupt, active low |

## Verification
The hard case is a pin change that must not raise the interrupt. This covers a change on an output-configured pin and a flip of the inversion mask alone. In both cases the reference must first be aligned with a select-0 read strobe. The bench then toggles only the excluded bits and shows `irq_no` stays high. Finally it moves one input bit and shows `irq_no` does fall. Without that last step, a stuck-high interrupt would pass the exclusion test unnoticed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_IN  = 2'd0,
    REG_OUT = 2'd1,
    REG_POL = 2'd2,
    REG_DIR = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  gpio_reg_e        sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] out_q_o,
  output logic [WIDTH-1:0] pol_q_o,
  output logic [WIDTH-1:0] dir_q_o
);
  localparam logic [WIDTH-1:0] ONES  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZEROS = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o <= ONES;
      pol_q_o <= ZEROS;
      dir_q_o <= ONES;
    end else if (wr_en_i) begin
      unique case (sel_i)
        REG_OUT: out_q_o <= wdata_i;
        REG_POL: pol_q_o <= wdata_i;
        REG_DIR: dir_q_o <= wdata_i;
        default: ;  // input register is read only
      endcase
    end
  end
endmodule

// File: rtl/gpio_change_det.sv
module gpio_change_det #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] dir_q_i,
  output logic             irq_no
);
  logic [WIDTH-1:0] ref_q;
  logic [WIDTH-1:0] ref_d;
  logic [WIDTH-1:0] diff;
  logic             irq_n_q;

  assign ref_d = capture_i ? pin_i : ref_q;

  // per-bit mismatch, qualified by input direction
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign diff[i] = dir_q_i[i] & (pin_i[i] ^ ref_d[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      irq_n_q <= 1'b1;
    end else begin
      ref_q   <= ref_d;
      irq_n_q <= ~|diff;
    end
  end

  assign irq_no = irq_n_q;
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  gpio_reg_e        sel_i,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] out_q_i,
  input  logic [WIDTH-1:0] pol_q_i,
  input  logic [WIDTH-1:0] dir_q_i,
  output logic [WIDTH-1:0] rdata_o
);
  always_comb begin
    unique case (sel_i)
      REG_IN:  rdata_o = pin_i ^ pol_q_i;
      REG_OUT: rdata_o = out_q_i;
      REG_POL: rdata_o = pol_q_i;
      REG_DIR: rdata_o = dir_q_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_o,
  output logic             irq_no
);
  gpio_reg_e        sel;
  logic [WIDTH-1:0] out_q, pol_q, dir_q;
  logic             capture;

  assign sel     = gpio_reg_e'(addr_i);
  assign capture = rd_en_i && (sel == REG_IN);

  gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .out_q_o (out_q),
    .pol_q_o (pol_q),
    .dir_q_o (dir_q)
  );

  gpio_change_det #(.WIDTH(WIDTH)) u_chg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .pin_i     (pin_i),
    .dir_q_i   (dir_q),
    .irq_no    (irq_no)
  );

  gpio_rd_mux #(.WIDTH(WIDTH)) u_rd (
    .sel_i   (sel),
    .pin_i   (pin_i),
    .out_q_i (out_q),
    .pol_q_i (pol_q),
    .dir_q_i (dir_q),
    .rdata_o (rdata_o)
  );

  // direction 0 = output; input pins drive a quiet 0
  assign oe_o  = ~dir_q;
  assign out_o = out_q & ~dir_q;
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [1:0]       addr_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic [WIDTH-1:0] pin_i,
  input logic [WIDTH-1:0] out_o,
  input logic [WIDTH-1:0] oe_o,
  input logic             irq_no
);
  // R5
  out_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o & ~oe_o) == '0);

  // R4
  out_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> (addr_i != 2'd1 || rdata_o == $past(wdata_i)));

  // R6
  in_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> ($stable(out_o) && $stable(oe_o)));

  // R8
  capture_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd0) |=> irq_no);

  // R10
  outputs_excluded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&oe_o) |=> irq_no);

  // R2
  in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0 && $stable(pin_i) && $stable(addr_i) && !$past(wr_en_i))
      |-> $stable(rdata_o));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_i   (pin_i),
  .out_o   (out_o),
  .oe_o    (oe_o),
  .irq_no  (irq_no)
);

// File: tb/gpio_port_bank_test.sv
`timescale 1ns/1ps
module gpio_port_bank_test;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic         rd_en_i = 1'b0;
  logic [1:0]   addr_i = 2'd0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic [W-1:0] pin_i = '0;
  logic [W-1:0] out_o;
  logic [W-1:0] oe_o;
  logic         irq_no;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  gpio_port_bank #(.WIDTH(W)) uut (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
    addr_i = 2'd0;
  endtask

  // select-0 read with strobe: loads the reference
  task automatic cap();
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = 2'd0;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    rd(2'd1, d); chk("R1 out reg", d, 8'hFF);
    rd(2'd2, d); chk("R1 pol reg", d, 8'h00);
    rd(2'd3, d); chk("R1 dir reg", d, 8'hFF);
    chk("R1 oe", oe_o, 8'h00);
    chk("R1 out pins", out_o, 8'h00);
    chk("R1 irq", {7'd0, irq_no}, 8'h01);
    @(negedge clk_i); pin_i = 8'h01;
    @(negedge clk_i);
    chk("R12 ref zero irq", {7'd0, irq_no}, 8'h00);
    cap();
    chk("R12 cleared by read", {7'd0, irq_no}, 8'h01);
  endtask

  task automatic t_polarity();
    logic [W-1:0] d;
    pin_i = 8'h3C;
    wr(2'd2, 8'hA5);
    rd(2'd2, d); chk("R3 pol readback", d, 8'hA5);
    rd(2'd0, d); chk("R3 inverted input", d, 8'h99);
    wr(2'd3, 8'h00);
    rd(2'd0, d); chk("R2 input with outputs", d, 8'h99);
    wr(2'd2, 8'h00);
    rd(2'd0, d); chk("R2 raw input", d, 8'h3C);
    wr(2'd3, 8'hFF);
    cap();
  endtask

  task automatic t_outputs();
    logic [W-1:0] d;
    pin_i = 8'h00;
    wr(2'd1, 8'h5A);
    wr(2'd3, 8'hF0);
    rd(2'd3, d); chk("R5 dir readback", d, 8'hF0);
    chk("R5 oe", oe_o, 8'h0F);
    chk("R5 out gated", out_o, 8'h0A);
    rd(2'd1, d); chk("R4 flop not pin", d, 8'h5A);
    wr(2'd3, 8'hFF);
    chk("R5 all inputs quiet", out_o, 8'h00);
    cap();
  endtask

  task automatic t_ignore_wr();
    logic [W-1:0] d;
    wr(2'd1, 8'hC3); wr(2'd2, 8'h0F); wr(2'd3, 8'h3F);
    pin_i = 8'h00; cap();
    wr(2'd0, 8'h77);
    rd(2'd1, d); chk("R6 out reg kept", d, 8'hC3);
    rd(2'd2, d); chk("R6 pol reg kept", d, 8'h0F);
    rd(2'd3, d); chk("R6 dir reg kept", d, 8'h3F);
    rd(2'd0, d); chk("R6 input read", d, 8'h0F);
    chk("R6 oe kept", oe_o, 8'hC0);
    chk("R6 irq kept", {7'd0, irq_no}, 8'h01);
    wr(2'd2, 8'h00); wr(2'd3, 8'hFF); wr(2'd1, 8'hFF);
    cap();
  endtask

  task automatic t_irq();
    pin_i = 8'h00; cap();
    @(negedge clk_i); pin_i = 8'h10;
    @(negedge clk_i);
    chk("R7 irq on change", {7'd0, irq_no}, 8'h00);
    pin_i = 8'h00;
    @(negedge clk_i);
    chk("R9 irq on return", {7'd0, irq_no}, 8'h01);
    pin_i = 8'h20;
    @(negedge clk_i);
    chk("R7 irq second bit", {7'd0, irq_no}, 8'h00);
    cap();
    chk("R8 read clears", {7'd0, irq_no}, 8'h01);
    @(negedge clk_i);
    chk("R8 stays clear", {7'd0, irq_no}, 8'h01);
  endtask

  task automatic t_irq_out();
    wr(2'd3, 8'h0F);
    pin_i = 8'h00; cap();
    @(negedge clk_i); pin_i = 8'hF0;
    @(negedge clk_i);
    chk("R10 output pins ignored", {7'd0, irq_no}, 8'h01);
    pin_i = 8'hF1;
    @(negedge clk_i);
    chk("R10 input pin counted", {7'd0, irq_no}, 8'h00);
    wr(2'd3, 8'hFF);
    cap();
  endtask

  task automatic t_irq_pol();
    pin_i = 8'h55; cap();
    wr(2'd2, 8'hFF);
    @(negedge clk_i);
    chk("R11 pol write no irq", {7'd0, irq_no}, 8'h01);
    pin_i = 8'h54;
    @(negedge clk_i);
    chk("R11 raw change irq", {7'd0, irq_no}, 8'h00);
    wr(2'd2, 8'h00);
    cap();
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_polarity();
    t_outputs();
    t_ignore_wr();
    t_irq();
    t_irq_out();
    t_irq_pol();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule